// File: doc/BRIEF.md
# Programmable Interval Timer with Expiry Interrupt

This block is an 8-bit down-counter for a small processor bus. Software starts it by writing a start count to a load address. Bits of that address pick how many clocks pass between decrements (1, 8, 64 or 1024) and whether the interrupt is enabled. Software can read the live count and a status byte at any time.

When the count steps down from zero, it wraps to 0xFF and raises an expiry flag. While the flag is up, the counter steps on every clock, whatever prescale was programmed. It keeps running that way until the next load, or until a count read lowers the flag. An active-low interrupt pin is driven low while the flag is up and interrupts are enabled.

The bus uses single-cycle strobes: `bus_en` together with `bus_we` is a write, and `bus_en` without `bus_we` is a read. Every access completes in the cycle it is presented. There is no back-pressure and no valid/ready handshake, because the block never stalls.

Top module: `itm_timer`

## Requirements
- R1: After reset the count is 0xFF, the flag is clear, interrupts are disabled, `irq_n` is 1 and the prescale is 1024.
- R2: A write with addr[2]=1 is a load. It sets the count to `wdata`, clears the flag and latches the interrupt enable from addr[3]. It also selects the prescale from addr[1:0]: 00 gives 1, 01 gives 8, 10 gives 64, 11 gives 1024.
- R3: With the flag clear, the first decrement after a load happens exactly N clocks after the load edge, where N is the prescale. Later decrements follow every N clocks.
- R4: A decrement from 0x00 gives 0xFF and sets the flag.
- R5: While the flag is set, the count decrements on every clock, including further wraps.
- R6: A read with addr[0]=0 returns the count on `rdata` in the same cycle and latches the interrupt enable from addr[3]. It also clears the flag, unless a wrap happens in that same cycle, in which case the flag stays set.
- R7: A read with addr[0]=1 returns the flag in bit 7 and zeros in bits 6:0.
- R8: `irq_n` is 0 exactly when the flag is set and interrupts are enabled.
- R9: When a load coincides with a wrap, the load wins and the flag ends clear.
- R10: A write with addr[2]=0 changes nothing, and `rdata` is 0 when no read is presented.
- R11: Once a count read clears the flag, stepping returns to the programmed prescale. The prescale phase counts on without a break from the last load.
- R12: The count seen by a read moves by at most one step per clock and never shows a zero that the counting sequence did not reach.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Register address and mode bits |
| wdata | input | 8 | Write data (start count) |
| rdata | output | 8 | Read data, valid in the cycle of the read |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Two pairs of events can fall in the same cycle: a load with a wrap, and a count read with a wrap. Each pair is provoked by loading 0 with prescale 1 and then issuing the second access on the very next clock. That clock is the one in which the counter steps below zero. A behavioural model in the bench applies the priority rules from R6 and R9 and predicts the result. A status read that follows shows whether the flag ended as the rules say, and `irq_n` is compared on every clock.

// File: rtl/itm_pkg.sv
package itm_pkg;

  typedef enum logic [1:0] {
    PS_1    = 2'b00,
    PS_8    = 2'b01,
    PS_64   = 2'b10,
    PS_1024 = 2'b11
  } ps_sel_e;

  typedef struct packed {
    logic    load;
    logic    rd_cnt;
    logic    rd_stat;
    logic    ien_bit;
    ps_sel_e ps;
  } bus_cmd_t;

endpackage

// File: rtl/itm_decode.sv
module itm_decode
  import itm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] addr,
  output bus_cmd_t          cmd
);

  always_comb begin
    cmd.load    = bus_en && bus_we && addr[2];
    cmd.rd_cnt  = bus_en && !bus_we && !addr[0];
    cmd.rd_stat = bus_en && !bus_we && addr[0];
    cmd.ien_bit = addr[3];
    cmd.ps      = ps_sel_e'(addr[1:0]);
  end

endmodule

// File: rtl/itm_prescaler.sv
module itm_prescaler
  import itm_pkg::*;
#(
  parameter int SH0 = 0,
  parameter int SH1 = 3,
  parameter int SH2 = 6,
  parameter int SH3 = 10,
  localparam int PRE_W = (SH3 > 0) ? SH3 : 1
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    load,
  input  ps_sel_e ps_new,
  output logic    base_tick
);

  localparam int SH_TAB [4] = '{SH0, SH1, SH2, SH3};

  logic [PRE_W-1:0] last_tab [4];
  logic [PRE_W-1:0] pre_q;
  ps_sel_e          sel_q;
  logic [PRE_W-1:0] last_now;

  for (genvar g = 0; g < 4; g++) begin : g_last
    assign last_tab[g] = PRE_W'((64'd1 << SH_TAB[g]) - 64'd1);
  end

  assign last_now  = last_tab[sel_q];
  assign base_tick = (pre_q == last_now);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      sel_q <= PS_1024;
    end else if (load) begin
      pre_q <= '0;
      sel_q <= ps_new;
    end else if (base_tick) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end

  // R3
  phase_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pre_q <= last_now);

endmodule

// File: rtl/itm_counter.sv
module itm_counter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              base_tick,
  input  logic              rd_cnt,
  output logic [DATA_W-1:0] cnt,
  output logic              flag
);

  localparam logic [DATA_W-1:0] ALL1 = '1;

  logic step;
  logic wrap;

  assign step = flag || base_tick;
  assign wrap = step && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= ALL1;
    end else if (load) begin
      cnt <= load_val;
    end else if (step) begin
      cnt <= cnt - DATA_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (load) begin
      flag <= 1'b0;
    end else if (wrap) begin
      flag <= 1'b1;
    end else if (rd_cnt) begin
      flag <= 1'b0;
    end
  end

  // R4
  wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && base_tick && cnt == '0) |=> (flag && cnt == ALL1));

  // R5
  fast_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && flag) |=> (cnt == $past(cnt) - DATA_W'(1)));

  // R12
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> (cnt == $past(cnt) || cnt == $past(cnt) - DATA_W'(1)));

  // R9
  load_beats_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> !flag);

endmodule

// File: rtl/itm_timer.sv
module itm_timer
  import itm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int SH0    = 0,
  parameter int SH1    = 3,
  parameter int SH2    = 6,
  parameter int SH3    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_n
);

  bus_cmd_t          cmd;
  logic              base_tick;
  logic [DATA_W-1:0] cnt;
  logic              flag;
  logic              ien_q;

  itm_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_en (bus_en),
    .bus_we (bus_we),
    .addr   (addr),
    .cmd    (cmd)
  );

  itm_prescaler #(.SH0(SH0), .SH1(SH1), .SH2(SH2), .SH3(SH3)) u_pre (
    .clk       (clk),
    .rst       (rst),
    .load      (cmd.load),
    .ps_new    (cmd.ps),
    .base_tick (base_tick)
  );

  itm_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .load      (cmd.load),
    .load_val  (wdata),
    .base_tick (base_tick),
    .rd_cnt    (cmd.rd_cnt),
    .cnt       (cnt),
    .flag      (flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q <= 1'b0;
    end else if (cmd.load || cmd.rd_cnt) begin
      ien_q <= cmd.ien_bit;
    end
  end

  always_comb begin
    rdata = '0;
    if (cmd.rd_cnt) begin
      rdata = cnt;
    end else if (cmd.rd_stat) begin
      rdata = '0;
      rdata[DATA_W-1] = flag;
    end
  end

  assign irq_n = !(flag && ien_q);

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_we && addr[2]) |=> (cnt == $past(wdata) && irq_n));

  // R3
  prescale_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmd.load && !flag && !base_tick) |=> $stable(cnt));

  // R7
  status_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !bus_we && addr[0]) |-> (rdata[DATA_W-2:0] == '0));

  // R8
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> flag);

  // R10
  idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_en && !bus_we) |-> (rdata == '0));

endmodule

// File: tb/tb_itm_timer.sv
module tb_itm_timer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_en = 1'b0;
  logic       bus_we = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq_n;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // behavioural model state
  int m_cnt, m_flag, m_pre, m_div, m_ien;

  always #10 clk = ~clk;

  itm_timer dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
  );

  function automatic int div_of(input logic [1:0] s);
    case (s)
      2'b00: return 1;
      2'b01: return 8;
      2'b10: return 64;
      default: return 1024;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one bus cycle: drive after negedge, check mid-cycle, update model at the edge
  task automatic cyc(input string req, input logic en, input logic we,
                     input logic [3:0] a, input logic [7:0] d);
    int exp_rd;
    int tick, wrp, ld, rdc;
    bus_en = en; bus_we = we; addr = a; wdata = d;
    #1;
    exp_rd = 0;
    if (en && !we) exp_rd = a[0] ? (m_flag << 7) : m_cnt;
    check(req, "rdata", int'(rdata), exp_rd);
    check(req, "irq_n", int'(irq_n), (m_flag && m_ien) ? 0 : 1);
    @(posedge clk);
    ld  = en && we && a[2];
    rdc = en && !we && !a[0];
    tick = m_flag || (m_pre == m_div - 1);
    wrp  = tick && (m_cnt == 0);
    if (ld) begin
      m_cnt = d; m_div = div_of(a[1:0]); m_pre = 0; m_flag = 0; m_ien = a[3];
    end else begin
      m_pre = (m_pre == m_div - 1) ? 0 : m_pre + 1;
      if (tick) m_cnt = (m_cnt == 0) ? 255 : m_cnt - 1;
      if (wrp) m_flag = 1;
      else if (rdc) m_flag = 0;
      if (rdc) m_ien = a[3];
    end
    @(negedge clk);
  endtask

  task automatic idle(input string req, input int n);
    for (int i = 0; i < n; i++) cyc(req, 1'b0, 1'b0, 4'h0, 8'h00);
  endtask

  task automatic stat(input string req, input int n);
    for (int i = 0; i < n; i++) cyc(req, 1'b1, 1'b0, 4'b0001, 8'h00);
  endtask

  task automatic rdcnt(input string req, input logic ie, input int n);
    for (int i = 0; i < n; i++) cyc(req, 1'b1, 1'b0, {ie, 3'b000}, 8'h00);
  endtask

  task automatic load(input string req, input logic ie, input logic [1:0] ps, input logic [7:0] v);
    cyc(req, 1'b1, 1'b1, {ie, 1'b1, ps}, v);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    m_cnt = 255; m_flag = 0; m_pre = 0; m_div = 1024; m_ien = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state seen through the bus
    rdcnt("R1", 1'b0, 1);
    stat("R1", 1);

    // R2 R4 R8: prescale 1 with interrupts on, watch wrap and irq
    load("R2", 1'b1, 2'b00, 8'd5);
    stat("R4", 8);
    // R5: flag set, stepping every clock
    stat("R5", 6);
    idle("R8", 3);
    // R6: count read with enable bit clear drops irq and flag
    rdcnt("R6", 1'b0, 1);
    stat("R6", 2);

    // R3 R12: prescale 8, poll the count through a wrap
    load("R3", 1'b0, 2'b01, 8'd2);
    rdcnt("R12", 1'b0, 40);

    // R3 prescale 64 then R11: flag raised, cleared by a read, slow again
    load("R3", 1'b1, 2'b10, 8'd0);
    stat("R3", 66);
    idle("R8", 5);
    rdcnt("R11", 1'b1, 1);
    stat("R11", 140);
    rdcnt("R11", 1'b1, 3);

    // R9: load lands on the wrap cycle
    load("R9", 1'b1, 2'b00, 8'd0);
    load("R9", 1'b1, 2'b00, 8'd10);
    stat("R9", 3);

    // R6: count read lands on the wrap cycle, flag must stay up
    load("R6", 1'b1, 2'b00, 8'd0);
    rdcnt("R6", 1'b1, 1);
    stat("R6", 3);

    // R10: writes with addr[2]=0 have no effect
    load("R10", 1'b0, 2'b11, 8'd77);
    cyc("R10", 1'b1, 1'b1, 4'b0000, 8'h11);
    cyc("R10", 1'b1, 1'b1, 4'b1011, 8'h22);
    rdcnt("R10", 1'b0, 2);
    stat("R10", 1);

    // R2: reload while flag is high restores the slow prescale
    load("R2", 1'b1, 2'b00, 8'd1);
    idle("R2", 4);
    load("R2", 1'b1, 2'b01, 8'd3);
    stat("R2", 20);
    rdcnt("R2", 1'b1, 12);

    // R2 prescale 1024: first step after a full period
    load("R2", 1'b0, 2'b11, 8'd1);
    idle("R3", 1022);
    rdcnt("R3", 1'b0, 4);

    finish_run();
  end

endmodule